// File: doc/BRIEF.md
# Shared Front-End Miss Stall Accounting

This block attributes front-end stall cycles to their causes at a low hardware cost. Instead of keeping a table entry for every outstanding branch, it keeps one shared accumulator for each front-end miss class: first-level instruction-cache miss, second-level instruction-cache miss and instruction-TLB miss. Each accumulator counts the stall cycles reported by fetch. The first instruction dispatched after a miss ends is marked. The mark is handed out on a tag-write output at dispatch, and the reorder buffer stores it beside the instruction. The reorder buffer itself is outside this block.

At retirement the stored mark comes back. A marked instruction commits the shared accumulators into the global counters. A retiring mispredicted branch throws the shared accumulators away and commits its own penalty. That penalty is collected in a single speculative register, which counts from the dispatch of the mispredicted branch until the first correct-path instruction dispatches after the redirect. Performance software reads the four global counters as a stall-cycle breakdown.

The retire stream must not present a mispredicted branch before the first correct-path instruction after its redirect has dispatched. Only one mispredicted branch is tracked at a time.

Top module: `fe_miss_acct`

## Requirements
- R1: After reset, all four global counters read zero and `disp_tag` is low.
- R2: Each cycle with a miss indication of one class adds exactly one to that class's shared accumulator. The three classes accumulate independently, and several may be active in the same cycle.
- R3: `disp_tag` is high for a dispatch (`disp_valid`=1) only when at least one miss cycle has occurred since the last dispatch and no miss indication is active in that cycle. A later dispatch with no miss in between gets `disp_tag`=0.
- R4: A retire with `ret_valid`=1 and `ret_tag`=1 adds each shared accumulator to its global counter, visible one cycle later. Each shared accumulator then restarts from zero.
- R5: If a miss cycle of a class arrives in the same cycle as a commit or a discard, that class's accumulator holds 1 afterwards instead of 0.
- R6: A retire with `ret_tag`=0 and `ret_br_bad`=0, or a cycle with `ret_valid`=0, leaves all four global counters unchanged.
- R7: The branch penalty equals the number of cycles strictly between the cycle in which a mispredicted branch dispatches (`disp_valid`=1, `disp_br_bad`=1) and the first cycle with `disp_valid`=1 after the cycle in which `fetch_redirect` was seen. The redirect cycle itself is counted. A retire with `ret_br_bad`=1 adds this penalty to `cnt_br` one cycle later and clears the speculative register.
- R8: A retire with `ret_br_bad`=1 discards the shared accumulators without committing them, unless `ret_tag` is also 1. In that case the accumulators are committed first (R4) and then cleared.
- R9: `ret_tag_clr` equals `ret_valid & ret_tag` in the same cycle. This tells the reorder buffer to clear the stored mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i1 | input | 1 | Fetch is stalled on a first-level instruction-cache miss this cycle |
| miss_i2 | input | 1 | Fetch is stalled on a second-level instruction-cache miss this cycle |
| miss_itlb | input | 1 | Fetch is stalled on an instruction-TLB miss this cycle |
| disp_valid | input | 1 | An instruction dispatches this cycle |
| disp_br_bad | input | 1 | The dispatching instruction is a branch that will mispredict |
| fetch_redirect | input | 1 | Fetch is redirected to the correct path this cycle |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_tag | input | 1 | Stored miss mark of the retiring instruction |
| ret_br_bad | input | 1 | The retiring instruction is a mispredicted branch |
| disp_tag | output | 1 | Mark to store with the dispatching instruction |
| ret_tag_clr | output | 1 | Clear the stored mark of the retiring instruction |
| cnt_i1 | output | GW | Global first-level instruction-cache stall cycles |
| cnt_i2 | output | GW | Global second-level instruction-cache stall cycles |
| cnt_itlb | output | GW | Global instruction-TLB stall cycles |
| cnt_br | output | GW | Global branch mispredict penalty cycles |

## Verification
Directed sequences cover several cases. A run of miss cycles followed by two dispatches shows that only the first dispatch gets the mark. A dispatch during a miss shows that the mark waits for the miss to end. A commit in the same cycle as a new miss shows that the new cycle lands in the cleared entry rather than being lost or committed early. An unmarked retire shows that the counters hold. In the mispredict sequence, wrong-path dispatches and idle cycles sit on both sides of the redirect; it fixes which cycles count toward the penalty and that the pending miss cycles are dropped. Random traffic with overlapping miss classes and a bench-modelled reorder-buffer queue then compares all four counters and the mark with a reference model on every cycle.

// File: rtl/fe_miss_acct_pkg.sv
package fe_miss_acct_pkg;
  localparam int NUM_CLASS = 3;
  localparam int CLS_I1    = 0;
  localparam int CLS_I2    = 1;
  localparam int CLS_ITLB  = 2;

  typedef enum logic [1:0] {
    BP_IDLE  = 2'd0,
    BP_RUN   = 2'd1,
    BP_DRAIN = 2'd2,
    BP_HELD  = 2'd3
  } bp_state_e;
endpackage

// File: rtl/fe_miss_entry.sv
module fe_miss_entry #(
  parameter int SW = 16,
  parameter int GW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss,
  input  logic          commit,
  input  logic          drop,
  output logic [SW-1:0] shared_q,
  output logic [GW-1:0] glob_q
);
  function automatic logic [SW-1:0] entry_next(input logic [SW-1:0] cur,
                                               input logic inc,
                                               input logic restart);
    logic [SW-1:0] step;
    step = SW'(inc);
    return restart ? step : cur + step;
  endfunction

  function automatic logic [GW-1:0] glob_next(input logic [GW-1:0] g,
                                              input logic [SW-1:0] s);
    return g + GW'(s);
  endfunction

  logic restart;
  assign restart = commit | drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shared_q <= '0;
      glob_q   <= '0;
    end else begin
      shared_q <= entry_next(shared_q, miss, restart);
      if (commit) glob_q <= glob_next(glob_q, shared_q);
    end
  end

  // R4: committed entry is added to the global counter
  a_r4_commit_adds: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> glob_q == $past(glob_q) + GW'($past(shared_q)));
  // R6: without commit the global counter holds
  a_r6_glob_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(glob_q));
  // R5: new miss cycle lands in freshly cleared entry
  a_r5_miss_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && miss) |=> shared_q == SW'(1));
  // R8: discard without a miss leaves an empty entry
  a_r8_entry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !miss) |=> shared_q == '0);
endmodule

// File: rtl/fe_miss_mark.sv
module fe_miss_mark (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_any,
  input  logic disp_valid,
  output logic disp_tag
);
  logic pend_q;

  assign disp_tag = disp_valid & pend_q & ~miss_any;

  always_ff @(posedge clk) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (miss_any)   pend_q <= 1'b1;
    else if (disp_valid) pend_q <= 1'b0;
  end

  // R3: no mark while a miss is still in progress
  a_r3_no_tag_in_miss: assert property (@(posedge clk) disable iff (!rst_n)
    disp_tag |-> !miss_any);
  // R3: only one mark per miss episode
  a_r3_single_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !miss_any) |=> !disp_tag);
endmodule

// File: rtl/fe_br_penalty.sv
module fe_br_penalty
  import fe_miss_acct_pkg::*;
#(
  parameter int SW = 16,
  parameter int GW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic          disp_br_bad,
  input  logic          fetch_redirect,
  input  logic          flush,
  output logic [GW-1:0] cnt_br
);
  bp_state_e     st_q;
  logic [SW-1:0] spec_q;
  logic          counting;

  function automatic logic [GW-1:0] br_next(input logic [GW-1:0] g,
                                            input logic [SW-1:0] p);
    return g + GW'(p);
  endfunction

  always_comb begin
    unique case (st_q)
      BP_RUN:   counting = 1'b1;
      BP_DRAIN: counting = !disp_valid;
      default:  counting = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BP_IDLE;
      spec_q <= '0;
      cnt_br <= '0;
    end else if (flush) begin
      cnt_br <= br_next(cnt_br, spec_q);
      spec_q <= '0;
      st_q   <= BP_IDLE;
    end else begin
      if (counting) spec_q <= spec_q + SW'(1);
      unique case (st_q)
        BP_IDLE: if (disp_valid && disp_br_bad) begin
          st_q   <= BP_RUN;
          spec_q <= '0;
        end
        BP_RUN:   if (fetch_redirect) st_q <= BP_DRAIN;
        BP_DRAIN: if (disp_valid) st_q <= BP_HELD;
        default:  st_q <= st_q;
      endcase
    end
  end

  // R7: branch counter moves only on a mispredicted retire
  a_r7_br_only_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(cnt_br));
  // R7: speculative register frozen once correct path dispatched
  a_r7_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BP_HELD && !flush) |=> $stable(spec_q));
  // R7: flush clears the speculative register
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_q == '0 && st_q == BP_IDLE));
endmodule

// File: rtl/fe_miss_acct.sv
module fe_miss_acct
  import fe_miss_acct_pkg::*;
#(
  parameter int SW = 16,
  parameter int GW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_i1,
  input  logic          miss_i2,
  input  logic          miss_itlb,
  input  logic          disp_valid,
  input  logic          disp_br_bad,
  input  logic          fetch_redirect,
  input  logic          ret_valid,
  input  logic          ret_tag,
  input  logic          ret_br_bad,
  output logic          disp_tag,
  output logic          ret_tag_clr,
  output logic [GW-1:0] cnt_i1,
  output logic [GW-1:0] cnt_i2,
  output logic [GW-1:0] cnt_itlb,
  output logic [GW-1:0] cnt_br
);
  logic [NUM_CLASS-1:0] miss_v;
  logic                 miss_any;
  logic                 commit_ev;
  logic                 flush_ev;
  logic [SW-1:0]        shared_a [NUM_CLASS];
  logic [GW-1:0]        glob_a   [NUM_CLASS];

  assign miss_v[CLS_I1]   = miss_i1;
  assign miss_v[CLS_I2]   = miss_i2;
  assign miss_v[CLS_ITLB] = miss_itlb;
  assign miss_any         = |miss_v;
  assign commit_ev        = ret_valid & ret_tag;
  assign flush_ev         = ret_valid & ret_br_bad;
  assign ret_tag_clr      = commit_ev;

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
    fe_miss_entry #(.SW(SW), .GW(GW)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .miss     (miss_v[k]),
      .commit   (commit_ev),
      .drop     (flush_ev),
      .shared_q (shared_a[k]),
      .glob_q   (glob_a[k])
    );
  end

  assign cnt_i1   = glob_a[CLS_I1];
  assign cnt_i2   = glob_a[CLS_I2];
  assign cnt_itlb = glob_a[CLS_ITLB];

  fe_miss_mark u_mark (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_any   (miss_any),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag)
  );

  fe_br_penalty #(.SW(SW), .GW(GW)) u_br (
    .clk            (clk),
    .rst_n          (rst_n),
    .disp_valid     (disp_valid),
    .disp_br_bad    (disp_br_bad),
    .fetch_redirect (fetch_redirect),
    .flush          (flush_ev),
    .cnt_br         (cnt_br)
  );

  // R9: mark clear follows a marked retire
  a_r9_clr_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ret_tag_clr |-> (ret_valid && ret_tag));
  // R1: counters are zero in the cycle after reset
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (cnt_i1 == '0 && cnt_i2 == '0 && cnt_itlb == '0 && cnt_br == '0));
endmodule

// File: tb/fe_miss_acct_tb_top.sv
`timescale 1ns/1ps
module fe_miss_acct_tb_top;
  localparam int SW = 16;
  localparam int GW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_i1 = 0, miss_i2 = 0, miss_itlb = 0;
  logic disp_valid = 0, disp_br_bad = 0, fetch_redirect = 0;
  logic ret_valid = 0, ret_tag = 0, ret_br_bad = 0;
  logic disp_tag, ret_tag_clr;
  logic [GW-1:0] cnt_i1, cnt_i2, cnt_itlb, cnt_br;

  always #10 clk = ~clk;

  fe_miss_acct #(.SW(SW), .GW(GW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .miss_i1(miss_i1), .miss_i2(miss_i2), .miss_itlb(miss_itlb),
    .disp_valid(disp_valid), .disp_br_bad(disp_br_bad),
    .fetch_redirect(fetch_redirect),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_br_bad(ret_br_bad),
    .disp_tag(disp_tag), .ret_tag_clr(ret_tag_clr),
    .cnt_i1(cnt_i1), .cnt_i2(cnt_i2), .cnt_itlb(cnt_itlb), .cnt_br(cnt_br)
  );

  int tests = 0;
  int fails = 0;

  // reference model
  logic [SW-1:0] m_sh [3];
  logic [GW-1:0] m_gl [3];
  logic [GW-1:0] m_br;
  logic [SW-1:0] m_spec;
  int            m_bst;
  logic          m_pend;
  // bench ROB: bit0 = mark, bit1 = mispredicted branch
  logic [1:0]    rob [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_tag(input logic dv, input logic anym);
    return dv && m_pend && !anym;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin m_sh[k] = '0; m_gl[k] = '0; end
    m_br = '0; m_spec = '0; m_bst = 0; m_pend = 1'b0;
    rob.delete();
  endtask

  task automatic model_step(input logic [2:0] m, input logic dv, input logic dbad,
                            input logic redir, input logic rv, input logic rtag,
                            input logic rbad);
    logic commit, flush, anym;
    anym   = |m;
    commit = rv && rtag;
    flush  = rv && rbad;
    for (int k = 0; k < 3; k++) begin
      if (commit) m_gl[k] = m_gl[k] + GW'(m_sh[k]);
      if (commit || flush) m_sh[k] = SW'(m[k]);
      else m_sh[k] = m_sh[k] + SW'(m[k]);
    end
    if (flush) begin
      m_br = m_br + GW'(m_spec); m_spec = '0; m_bst = 0;
    end else begin
      case (m_bst)
        0: if (dv && dbad) begin m_bst = 1; m_spec = '0; end
        1: begin m_spec = m_spec + 1'b1; if (redir) m_bst = 2; end
        2: if (dv) m_bst = 3; else m_spec = m_spec + 1'b1;
        default: ;
      endcase
    end
    if (anym) m_pend = 1'b1;
    else if (dv) m_pend = 1'b0;
  endtask

  // one clock: drive at negedge, check combinational outputs, advance, check counters
  task automatic cyc(input logic [2:0] m, input logic dv, input logic dbad,
                     input logic redir, input logic rv, input logic rtag,
                     input logic rbad, input string req);
    logic et;
    miss_i1 = m[0]; miss_i2 = m[1]; miss_itlb = m[2];
    disp_valid = dv; disp_br_bad = dbad; fetch_redirect = redir;
    ret_valid = rv; ret_tag = rtag; ret_br_bad = rbad;
    #1;
    et = exp_tag(dv, |m);
    chk({"R3 disp_tag ", req}, 64'(disp_tag), 64'(et));
    chk("R9 ret_tag_clr", 64'(ret_tag_clr), 64'(rv && rtag));
    if (dv) rob.push_back({dbad, et});
    model_step(m, dv, dbad, redir, rv, rtag, rbad);
    @(posedge clk);
    @(negedge clk);
    chk({"R2/R4 cnt_i1 ", req}, 64'(cnt_i1), 64'(m_gl[0]));
    chk({"R2/R4 cnt_i2 ", req}, 64'(cnt_i2), 64'(m_gl[1]));
    chk({"R2/R4 cnt_itlb ", req}, 64'(cnt_itlb), 64'(m_gl[2]));
    chk({"R7 cnt_br ", req}, 64'(cnt_br), 64'(m_br));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'b000, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [GW-1:0] base;
    void'($urandom(32'd1234));
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cnt_i1", 64'(cnt_i1), 0);
    chk("R1 cnt_i2", 64'(cnt_i2), 0);
    chk("R1 cnt_itlb", 64'(cnt_itlb), 0);
    chk("R1 cnt_br", 64'(cnt_br), 0);
    chk("R1 disp_tag", 64'(disp_tag), 0);

    // R2/R3/R4: 3 I1 miss cycles, two dispatches, marked retire
    for (int i = 0; i < 3; i++) cyc(3'b001, 0, 0, 0, 0, 0, 0, "i1 miss");
    cyc(3'b000, 1, 0, 0, 0, 0, 0, "first after miss");
    chk("R3 first dispatch marked", 64'(rob[$][0]), 1);
    cyc(3'b000, 1, 0, 0, 0, 0, 0, "second after miss");
    chk("R3 second dispatch unmarked", 64'(rob[$][0]), 0);
    cyc(3'b000, 0, 0, 0, 1, 1, 0, "marked retire");
    chk("R4 cnt_i1 after commit", 64'(cnt_i1), 3);
    rob.delete();

    // R3: dispatch during miss is not marked
    cyc(3'b100, 1, 0, 0, 0, 0, 0, "dispatch in miss");
    chk("R3 dispatch in miss unmarked", 64'(rob[$][0]), 0);
    cyc(3'b000, 1, 0, 0, 0, 0, 0, "after tlb miss");
    chk("R3 dispatch after tlb miss marked", 64'(rob[$][0]), 1);

    // R5: commit coincides with new I2 miss
    cyc(3'b010, 0, 0, 0, 1, 1, 0, "commit with miss");
    chk("R4 cnt_itlb committed", 64'(cnt_itlb), 1);
    cyc(3'b000, 0, 0, 0, 1, 1, 0, "commit leftover");
    chk("R5 miss in commit cycle lands", 64'(cnt_i2), 1);

    // R6: unmarked retire does nothing
    for (int i = 0; i < 2; i++) cyc(3'b001, 0, 0, 0, 0, 0, 0, "pre r6");
    base = cnt_i1;
    cyc(3'b000, 0, 0, 0, 1, 0, 0, "unmarked retire");
    chk("R6 unmarked retire holds cnt_i1", 64'(cnt_i1), 64'(base));

    // R7/R8: branch penalty with wrong-path dispatch; shared dropped
    cyc(3'b000, 1, 1, 0, 0, 0, 0, "bad branch dispatch");
    cyc(3'b100, 1, 0, 0, 0, 0, 0, "wrong path");
    idle(3);
    cyc(3'b000, 0, 0, 1, 0, 0, 0, "redirect");
    idle(2);
    cyc(3'b000, 1, 0, 0, 0, 0, 0, "correct path");
    idle(2);
    base = cnt_br;
    cyc(3'b000, 0, 0, 0, 1, 0, 1, "bad branch retire");
    chk("R7 penalty cycles", 64'(cnt_br - base), 7);
    base = cnt_i1;
    cyc(3'b000, 0, 0, 0, 1, 1, 0, "commit after flush");
    chk("R8 i1 dropped by flush", 64'(cnt_i1), 64'(base));
    chk("R8 itlb dropped by flush", 64'(cnt_itlb), 1);
    rob.delete();

    // random traffic with bench ROB
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] m;
      logic dv, dbad, redir, rv, rtag, rbad;
      m = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) != 0) m = 3'b000;
      dv = ($urandom_range(0, 1) == 1);
      dbad = dv && (m_bst == 0) && ($urandom_range(0, 9) == 0);
      redir = (m_bst == 1) && ($urandom_range(0, 3) == 0);
      rv = 0; rtag = 0; rbad = 0;
      if (rob.size() > 0 && $urandom_range(0, 1) == 1) begin
        if (!(rob[0][1] && m_bst != 3)) begin
          rv = 1; rtag = rob[0][0]; rbad = rob[0][1];
          void'(rob.pop_front());
        end
      end
      cyc(m, dv, dbad, redir, rv, rtag, rbad, "random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule